// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block turns single-beat requests from an internal port into cycles on an external asynchronous SRAM. The SRAM sits behind a narrow, time-shared bus. One byte lane carries the low address byte first and the data byte after it. The high address byte has dedicated pins. An address strobe tells an external transparent latch when to hold the low byte. Active-low read and write strobes, together with a wait-state setting, shape the data phase.

An address decoder compares each request with a parameterised internal-memory top address. Only addresses above that top, with the external interface enabled, start an external cycle. An internal address produces a one-clock internal access that drives the low address byte on the lane and nothing else. A high address that arrives while the interface is disabled is consumed without any bus activity.

The byte lane is modelled with separate output, output-enable and input signals. A bus-keeper model reports the value it holds whenever the controller releases the lane and the keeper is enabled.

The controller has six states:
- `ST_IDLE`: waits for a request.
- `ST_ADDR`: the address strobe is high.
- `ST_HOLD`: the address strobe is low and the address is still driven.
- `ST_STRB`: the read or write strobe is low.
- `ST_REL`: the strobe is released and the response is given.
- `ST_INTA`: the one-clock internal access.

It has these transitions:
- `ST_IDLE` to `ST_ADDR` on an accepted external request.
- `ST_IDLE` to `ST_INTA` on an accepted internal request.
- `ST_IDLE` to `ST_IDLE` on a dropped request.
- `ST_ADDR` to `ST_HOLD`, always.
- `ST_HOLD` to `ST_STRB`, always.
- `ST_STRB` to `ST_STRB` while wait states remain.
- `ST_STRB` to `ST_REL` on the last strobe clock.
- `ST_REL` to `ST_IDLE`, always.
- `ST_INTA` to `ST_IDLE`, always.

Top module: `muxbus_ctrl`

## Requirements
- R1: After reset the controller is idle: `req_ready`=1, `ext_ale`=0, `ext_rd_n`=`ext_wr_n`=1, `ext_ad_oe`=0, `rsp_done`=0.
- R2: In the clock after an external request is accepted, `ext_ale`=1 for exactly one clock. During that clock `ext_ad_oe`=1, `ext_ad_out` is the address bits [7:0], `ext_addr_hi` is the address bits [15:8], and both strobes are high.
- R3: In the clock after the address strobe, `ext_ale`=0 while `ext_ad_out` still drives the same low address byte with `ext_ad_oe`=1 and both strobes high.
- R4: The strobe phase lasts 1 + `cfg_wait` clocks. `cfg_wait` is 2 bits, and its value is captured when the request is accepted. `ext_wr_n` is the strobe for writes and `ext_rd_n` is the strobe for reads, and the two are never low together.
- R5: During a write strobe, `ext_ad_oe`=1 and `ext_ad_out` carries the write data. In the release clock after it, `ext_ad_oe`=0.
- R6: During a read strobe and its release clock, `ext_ad_oe`=0. `rsp_rdata` is the `ext_ad_in` value sampled at the last strobe clock and is valid while `rsp_done`=1.
- R7: `rsp_done` is high for exactly one clock per external cycle, in the release clock after the strobe. `req_ready` is high only when the controller is idle.
- R8: With `cfg_keep_en`=1 and `ext_ad_oe`=0, `ext_keep_oe`=1 and `ext_keep_val` is the last value the controller drove on the lane.
- R9: With `cfg_keep_en`=0, after a read nothing drives the lane: `ext_ad_oe`=0 and `ext_keep_oe`=0 until the next accepted access. An internal access drives the low address byte (`ext_ad_oe`=1) for one clock.
- R10: A request whose address is at or below `INT_TOP` causes no address strobe, no read or write strobe, and no `rsp_done`.
- R11: With `cfg_xmem_en`=0, a request above `INT_TOP` is consumed with no strobe, no lane drive and no `rsp_done`.
- R12: `ext_addr_hi` stays stable through the whole strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_xmem_en | input | 1 | External interface enable |
| cfg_keep_en | input | 1 | Bus-keeper enable |
| cfg_wait | input | 2 | Wait states added to the strobe phase |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-clock completion of an external cycle |
| rsp_rdata | output | 8 | Read data |
| ext_ale | output | 1 | Address latch strobe (latch transparent while high) |
| ext_addr_hi | output | 8 | High address byte |
| ext_ad_out | output | 8 | Value driven on the shared lane |
| ext_ad_oe | output | 1 | Controller drives the shared lane |
| ext_ad_in | input | 8 | Value seen on the shared lane |
| ext_keep_oe | output | 1 | Keeper is holding the lane |
| ext_keep_val | output | 8 | Value held by the keeper |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |

## Verification
The bench uses the default parameters: a 16-bit address, an 8-bit lane, a 2-bit wait field and an internal top of 0x025F. The 2-bit wait field lets the bench run all four strobe lengths, for both reads and writes, against a behavioural latch and SRAM. With the 0x025F top, the bench can place requests exactly at the boundary and just above it. It can also reach the floating-lane and keeper cases after both reads and writes.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_STRB,
        ST_REL,
        ST_INTA
    } mbc_state_e;

endpackage

// File: rtl/mbc_decode.sv
module mbc_decode #(
    parameter int                 ADDR_W  = 16,
    parameter logic [ADDR_W-1:0]  INT_TOP = 16'h025F
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              xmem_en,
    output logic              go_ext,
    output logic              go_int
);

    logic above_top;

    always_comb begin
        above_top = (addr > INT_TOP);
        go_int    = !above_top;
        go_ext    = above_top && xmem_en;
    end

endmodule

// File: rtl/mbc_wait_cnt.sv
module mbc_wait_cnt #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              step,
    output logic              last
);

    logic [WAIT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (step && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign last = (remain == '0);

endmodule

// File: rtl/mbc_keeper.sv
module mbc_keeper #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keep_en,
    input  logic              drv_oe,
    input  logic [DATA_W-1:0] drv_val,
    output logic              keep_oe,
    output logic [DATA_W-1:0] keep_val
);

    logic [DATA_W-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (drv_oe) begin
            held <= drv_val;
        end
    end

    assign keep_oe  = keep_en && !drv_oe;
    assign keep_val = held;

endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
    import muxbus_pkg::*;
#(
    parameter int                 ADDR_W  = 16,
    parameter int                 DATA_W  = 8,
    parameter int                 WAIT_W  = 2,
    parameter logic [ADDR_W-1:0]  INT_TOP = 16'h025F
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_xmem_en,
    input  logic                     cfg_keep_en,
    input  logic [WAIT_W-1:0]        cfg_wait,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     ext_ale,
    output logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
    output logic [DATA_W-1:0]        ext_ad_out,
    output logic                     ext_ad_oe,
    input  logic [DATA_W-1:0]        ext_ad_in,
    output logic                     ext_keep_oe,
    output logic [DATA_W-1:0]        ext_keep_val,
    output logic                     ext_rd_n,
    output logic                     ext_wr_n
);

    localparam int HI_W = ADDR_W - DATA_W;

    mbc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept;
    logic              go_ext;
    logic              go_int;
    logic              strb_last;
    logic              in_strb;

    mbc_decode #(
        .ADDR_W  (ADDR_W),
        .INT_TOP (INT_TOP)
    ) i_decode (
        .addr    (req_addr),
        .xmem_en (cfg_xmem_en),
        .go_ext  (go_ext),
        .go_int  (go_int)
    );

    mbc_wait_cnt #(
        .WAIT_W   (WAIT_W)
    ) i_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cfg_wait),
        .step     (in_strb),
        .last     (strb_last)
    );

    mbc_keeper #(
        .DATA_W   (DATA_W)
    ) i_keeper (
        .clk      (clk),
        .rst_n    (rst_n),
        .keep_en  (cfg_keep_en),
        .drv_oe   (ext_ad_oe),
        .drv_val  (ext_ad_out),
        .keep_oe  (ext_keep_oe),
        .keep_val (ext_keep_val)
    );

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign in_strb = (state_q == ST_STRB);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && go_ext) begin
                    state_d = ST_ADDR;
                end else if (accept && go_int) begin
                    state_d = ST_INTA;
                end
            end
            ST_ADDR: state_d = ST_HOLD;
            ST_HOLD: state_d = ST_STRB;
            ST_STRB: if (strb_last) state_d = ST_REL;
            ST_REL:  state_d = ST_IDLE;
            ST_INTA: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept && (go_ext || go_int)) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
            end
            if (in_strb && strb_last && !write_q) begin
                rdata_q <= ext_ad_in;
            end
        end
    end

    // outputs per state
    always_comb begin
        req_ready  = 1'b0;
        rsp_done   = 1'b0;
        ext_ale    = 1'b0;
        ext_ad_oe  = 1'b0;
        ext_ad_out = addr_q[DATA_W-1:0];
        ext_rd_n   = 1'b1;
        ext_wr_n   = 1'b1;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_ADDR: begin
                ext_ale   = 1'b1;
                ext_ad_oe = 1'b1;
            end
            ST_HOLD: ext_ad_oe = 1'b1;
            ST_STRB: begin
                if (write_q) begin
                    ext_wr_n   = 1'b0;
                    ext_ad_oe  = 1'b1;
                    ext_ad_out = wdata_q;
                end else begin
                    ext_rd_n   = 1'b0;
                end
            end
            ST_REL:  rsp_done  = 1'b1;
            ST_INTA: ext_ad_oe = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

    assign ext_addr_hi = addr_q[ADDR_W-1 -: HI_W];
    assign rsp_rdata   = rdata_q;

endmodule

// File: rtl/mbc_checker.sv
module mbc_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_ready,
    input logic                     rsp_done,
    input logic                     ext_ale,
    input logic [ADDR_W-DATA_W-1:0] ext_addr_hi,
    input logic [DATA_W-1:0]        ext_ad_out,
    input logic                     ext_ad_oe,
    input logic                     ext_keep_oe,
    input logic                     ext_rd_n,
    input logic                     ext_wr_n
);

    assert_ale_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ale |-> (ext_ad_oe && ext_rd_n && ext_wr_n));

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ale |=> !ext_ale);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_ale) |-> (ext_ad_oe && $stable(ext_ad_out)));

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_n |-> ext_ad_oe);

    assert_read_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n |-> !ext_ad_oe);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

    assert_done_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_done) |-> ($past(!ext_rd_n) || $past(!ext_wr_n)));

    assert_keeper_yield_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_keep_oe |-> !ext_ad_oe);

    assert_hi_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ext_rd_n || !ext_wr_n) && $past(!ext_rd_n || !ext_wr_n)) |-> $stable(ext_addr_hi));

endmodule

bind muxbus_ctrl mbc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .ext_ale     (ext_ale),
    .ext_addr_hi (ext_addr_hi),
    .ext_ad_out  (ext_ad_out),
    .ext_ad_oe   (ext_ad_oe),
    .ext_keep_oe (ext_keep_oe),
    .ext_rd_n    (ext_rd_n),
    .ext_wr_n    (ext_wr_n)
);

// File: tb/test_muxbus_ctrl.sv
`timescale 1ns/1ps
module test_muxbus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_xmem_en = 1'b1;
    logic        cfg_keep_en = 1'b0;
    logic [1:0]  cfg_wait = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic        ext_ale;
    logic [7:0]  ext_addr_hi;
    logic [7:0]  ext_ad_out;
    logic        ext_ad_oe;
    logic [7:0]  ext_ad_in;
    logic        ext_keep_oe;
    logic [7:0]  ext_keep_val;
    logic        ext_rd_n;
    logic        ext_wr_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    muxbus_ctrl i_muxbus_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_xmem_en  (cfg_xmem_en),
        .cfg_keep_en  (cfg_keep_en),
        .cfg_wait     (cfg_wait),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rsp_done     (rsp_done),
        .rsp_rdata    (rsp_rdata),
        .ext_ale      (ext_ale),
        .ext_addr_hi  (ext_addr_hi),
        .ext_ad_out   (ext_ad_out),
        .ext_ad_oe    (ext_ad_oe),
        .ext_ad_in    (ext_ad_in),
        .ext_keep_oe  (ext_keep_oe),
        .ext_keep_val (ext_keep_val),
        .ext_rd_n     (ext_rd_n),
        .ext_wr_n     (ext_wr_n)
    );

    // behavioural latch and SRAM
    logic [7:0] sram [logic [15:0]];
    logic [7:0] exp_mem [logic [15:0]];
    logic [7:0] lat_q = '0;
    logic [7:0] bus_v;

    function automatic logic [7:0] sram_rd(input logic [15:0] a);
        return sram.exists(a) ? sram[a] : 8'hA5;
    endfunction

    always @* begin
        if (ext_ad_oe)        bus_v = ext_ad_out;
        else if (!ext_rd_n)   bus_v = sram_rd({ext_addr_hi, lat_q});
        else if (ext_keep_oe) bus_v = ext_keep_val;
        else                  bus_v = 8'h00;
    end
    assign ext_ad_in = bus_v;

    always @* if (ext_ale) lat_q = bus_v;

    always @(posedge clk) begin
        if (rst_n && !ext_wr_n && ext_ad_oe) sram[{ext_addr_hi, lat_q}] = bus_v;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard
    typedef struct { bit is_rd; logic [7:0] data; } exp_t;
    exp_t sb_q [$];

    always @(negedge clk) begin
        if (rst_n && rsp_done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.is_rd) check(rsp_rdata == e.data, "R6", "read data", rsp_rdata, e.data);
                else         check(1'b1, "R7", "write done", 1, 1);
            end
        end
    end

    task automatic ext_access(input bit wr, input logic [15:0] a,
                              input logic [7:0] d, input logic [1:0] w);
        exp_t e;
        @(negedge clk);
        check(req_ready == 1'b1, "R7", "ready idle", req_ready, 1);
        cfg_wait = w; req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        e.is_rd = !wr;
        e.data  = exp_mem.exists(a) ? exp_mem[a] : 8'hA5;
        if (wr) exp_mem[a] = d;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0; cfg_wait = ~w;
        check(ext_ale && ext_ad_oe && ext_rd_n && ext_wr_n, "R2", "address phase ctl", ext_ale, 1);
        check(ext_ad_out == a[7:0], "R2", "low addr", ext_ad_out, a[7:0]);
        check(ext_addr_hi == a[15:8], "R2", "high addr", ext_addr_hi, a[15:8]);
        check(req_ready == 1'b0, "R7", "ready busy", req_ready, 0);
        @(negedge clk);
        check(!ext_ale && ext_ad_oe && ext_ad_out == a[7:0] && ext_rd_n && ext_wr_n,
              "R3", "hold phase", ext_ad_out, a[7:0]);
        for (int i = 0; i <= int'(w); i++) begin
            @(negedge clk);
            if (wr) begin
                check(!ext_wr_n && ext_rd_n, "R4", "write strobe", ext_wr_n, 0);
                check(ext_ad_oe && ext_ad_out == d, "R5", "write data", ext_ad_out, d);
            end else begin
                check(!ext_rd_n && ext_wr_n, "R4", "read strobe", ext_rd_n, 0);
                check(!ext_ad_oe, "R6", "read lane released", ext_ad_oe, 0);
            end
            check(ext_addr_hi == a[15:8], "R12", "high addr in strobe", ext_addr_hi, a[15:8]);
            check(rsp_done == 1'b0, "R7", "no early done", rsp_done, 0);
        end
        @(negedge clk);
        check(ext_rd_n && ext_wr_n, "R4", "strobe length", {ext_rd_n, ext_wr_n}, 3);
        check(rsp_done == 1'b1, "R7", "done in release", rsp_done, 1);
        check(!ext_ad_oe, "R5", "release lane", ext_ad_oe, 0);
        @(negedge clk);
        check(rsp_done == 1'b0 && req_ready, "R7", "done one clock", rsp_done, 0);
    endtask

    task automatic other_access(input logic [15:0] a, input bit is_int);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (is_int) begin
            check(ext_ad_oe && ext_ad_out == a[7:0], "R9", "internal drives addr", ext_ad_out, a[7:0]);
        end else begin
            check(!ext_ad_oe, "R11", "disabled no drive", ext_ad_oe, 0);
        end
        for (int i = 0; i < 4; i++) begin
            if (i > 0) @(negedge clk);
            if (is_int)
                check(!ext_ale && ext_rd_n && ext_wr_n && !rsp_done, "R10", "no ext cycle", ext_ale, 0);
            else
                check(!ext_ale && ext_rd_n && ext_wr_n && !rsp_done, "R11", "no ext cycle", ext_ale, 0);
        end
        check(!ext_ad_oe && req_ready, "R9", "lane released after", ext_ad_oe, 0);
    endtask

    task automatic float_check(input string req);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(!ext_ad_oe && !ext_keep_oe, req, "lane floating", {ext_ad_oe, ext_keep_oe}, 0);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        check(1'b0, "R7", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && !ext_ale && ext_rd_n && ext_wr_n && !ext_ad_oe && !rsp_done,
              "R1", "reset state", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !ext_ad_oe && !rsp_done, "R1", "idle after reset", req_ready, 1);

        for (int w = 0; w < 4; w++) begin
            ext_access(1'b1, 16'h1200 + 16'(w * 17), 8'h3C ^ 8'(w), 2'(w));
            ext_access(1'b0, 16'h1200 + 16'(w * 17), 8'h00, 2'(3 - w));
            float_check("R9");
        end
        ext_access(1'b0, 16'hF0F0, 8'h00, 2'd1);
        ext_access(1'b0, 16'h0260, 8'h00, 2'd0);
        other_access(16'h025F, 1'b1);
        other_access(16'h0100, 1'b1);
        float_check("R9");

        cfg_keep_en = 1'b1;
        ext_access(1'b1, 16'h8001, 8'h5A, 2'd2);
        @(negedge clk);
        check(ext_keep_oe && ext_keep_val == 8'h5A, "R8", "keeper after write", ext_keep_val, 8'h5A);
        ext_access(1'b0, 16'h8001, 8'h00, 2'd3);
        @(negedge clk);
        check(ext_keep_oe && ext_keep_val == 8'h01, "R8", "keeper after read", ext_keep_val, 8'h01);
        ext_access(1'b1, 16'hABCD, 8'hC3, 2'd0);
        ext_access(1'b0, 16'hABCD, 8'h00, 2'd2);

        cfg_keep_en = 1'b0;
        cfg_xmem_en = 1'b0;
        other_access(16'h9000, 1'b0);
        cfg_xmem_en = 1'b1;
        ext_access(1'b0, 16'h9000, 8'h00, 2'd0);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R7", "scoreboard drained", sb_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule